// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects up to eight edge-triggered interrupt requests, latches each rising edge into a request register, and filters the pending set through a writable mask. The lowest-numbered request that is pending and unmasked is reported as a vector number: the programmed base plus the input number. A processor-side acknowledge moves that request into an in-service register. An end-of-interrupt command then retires it. Input 0 has the highest priority, and the priority order never changes.

Software sees a byte-wide port with one address line. Address 0 takes command words and returns a selectable status byte. Address 1 takes the initialization data and the mask. A command-word sequencer is started by any command-address write with bit 4 set. It takes the vector base and the optional follow-up words, then enters its ready state. In the ready state, command-address writes are decoded as end-of-interrupt commands or as the read-select command. Only a single controller is supported, with no chaining to others.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, the request, in-service and mask registers are zero, int_o is low, and a command-address read returns the request register. Until a start word is seen, data-address writes have no effect.
- R2: A command-address write with bit 4 set starts initialization in any state. The next data-address write loads the vector base and does not change the mask.
- R3: In the start word, bit 1 = 1 means single mode, which skips the chaining word. Bit 0 = 1 means one more option word follows. Each word that is expected is taken by one data-address write. The sequencer becomes ready only after the last expected word.
- R4: vector_o equals the vector base plus the number of the highest-priority pending unmasked input, modulo 256.
- R5: In the ready state, a data-address write loads the mask, and a data-address read returns it. A masked request is still latched, but it does not raise int_o.
- R6: A rising edge on irq_req_i[n] sets request bit n one clock later. The bit stays set until acknowledged. An input held high does not set the bit again.
- R7: Input 0 has the highest priority. int_o is high exactly when some unmasked request is pending and no in-service bit at the same or a higher priority than the best pending one is set.
- R8: When ack_i is high and some unmasked request is pending, the best such request moves from the request register to the in-service register. Otherwise ack_i has no effect.
- R9: A ready-state command write with bits 7:3 = 01100 clears the in-service bit whose number is in bits 2:0.
- R10: A ready-state command write with bits 7:3 = 00100 clears only the lowest-numbered set in-service bit.
- R11: Other ready-state command writes with bits 4:3 = 00 (such as 0x00, 0x40 or 0xA0) leave the in-service register unchanged.
- R12: A ready-state command write with bits 4:3 = 01 stores its bits 1:0 as the read select. A command-address read then returns the request register for 10, the in-service register for 11, and zero for 00 or 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe, one byte per cycle |
| addr_i | input | 1 | Port address: 0 = command, 1 = data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_req_i | input | 8 | Edge-triggered request inputs |
| ack_i | input | 1 | Interrupt acknowledge, one cycle |
| int_o | output | 1 | Interrupt pending to processor |
| vector_o | output | 8 | Vector of the best pending request |

## Verification
A corrupted request or in-service bit shows up on int_o and vector_o in the next cycle. It can also be read back on the command address at once. A sequencer that lands in the wrong state shows on the following data write: the mask readback does not change, or the vector base moves. Wrong end-of-interrupt decoding leaves a stale in-service bit. That stale bit holds int_o low for lower-priority requests, and the next in-service readback exposes it.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DW    = 8;
  localparam int N_IN  = 8;
  localparam int IDX_W = $clog2(N_IN);

  localparam int BIT_START = 4;
  localparam int BIT_EOI   = 5;
  localparam int BIT_SL    = 6;
  localparam int BIT_ROT   = 7;

  localparam logic [1:0] RSEL_REQ = 2'b10;
  localparam logic [1:0] RSEL_ISV = 2'b11;

  typedef enum logic [2:0] {
    SEQ_WAIT_START,
    SEQ_WAIT_BASE,
    SEQ_WAIT_CHAIN,
    SEQ_WAIT_OPT,
    SEQ_READY
  } seq_state_e;
endpackage

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq
  import irq_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    base_o,
  output logic [N_IN-1:0]  mask_o,
  output logic [1:0]       rsel_o,
  output logic             ready_o,
  output logic             eoi_spec_o,
  output logic             eoi_ns_o,
  output logic [IDX_W-1:0] eoi_lvl_o
);
  seq_state_e state_q;
  logic [1:0] start_q; // [1] single, [0] option word follows
  logic       start_hit, ready_cmd;

  assign start_hit = wr_i && !addr_i && wdata_i[BIT_START];
  assign ready_o   = (state_q == SEQ_READY);
  assign ready_cmd = wr_i && !addr_i && ready_o && (wdata_i[4:3] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_WAIT_START;
      start_q <= '0;
      base_o  <= '0;
      mask_o  <= '0;
      rsel_o  <= RSEL_REQ;
    end else if (start_hit) begin
      start_q <= wdata_i[1:0];
      state_q <= SEQ_WAIT_BASE;
    end else if (wr_i) begin
      unique case (state_q)
        SEQ_WAIT_BASE: if (addr_i) begin
          base_o  <= wdata_i;
          state_q <= !start_q[1] ? SEQ_WAIT_CHAIN :
                     (start_q[0] ? SEQ_WAIT_OPT : SEQ_READY);
        end
        SEQ_WAIT_CHAIN: if (addr_i)
          state_q <= start_q[0] ? SEQ_WAIT_OPT : SEQ_READY;
        SEQ_WAIT_OPT: if (addr_i)
          state_q <= SEQ_READY;
        SEQ_READY: begin
          if (addr_i) mask_o <= wdata_i[N_IN-1:0];
          else if (wdata_i[4:3] == 2'b01) rsel_o <= wdata_i[1:0];
        end
        default: ;
      endcase
    end
  end

  assign eoi_spec_o = ready_cmd && wdata_i[BIT_EOI] && !wdata_i[BIT_ROT] && wdata_i[BIT_SL];
  assign eoi_ns_o   = ready_cmd && wdata_i[BIT_EOI] && !wdata_i[BIT_ROT] && !wdata_i[BIT_SL];
  assign eoi_lvl_o  = wdata_i[IDX_W-1:0];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] && !prev_q;
  end
endmodule

// File: rtl/irq_prio_res.sv
module irq_prio_res #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  isv_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic          open_o
);
  logic [IW-1:0] idx;
  logic          blk;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend_i[i]) idx = IW'(i);
    blk = 1'b0;
    for (int i = 0; i < N; i++)
      if (IW'(i) <= idx && isv_i[i]) blk = 1'b1;
  end

  assign any_o  = |pend_i;
  assign idx_o  = idx;
  assign open_o = !blk;
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
  import irq_ctrl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [N_IN-1:0] irq_req_i,
  input  logic            ack_i,
  output logic            int_o,
  output logic [DW-1:0]   vector_o
);
  logic [N_IN-1:0]  irr_q, isr_q, mask, rise, pend, ack_oh, eoi_clr;
  logic [DW-1:0]    base;
  logic [1:0]       rsel;
  logic             seq_ready, eoi_spec, eoi_ns, pend_any, path_open;
  logic [IDX_W-1:0] eoi_lvl, best;

  irq_cmd_seq u_seq (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .base_o(base), .mask_o(mask), .rsel_o(rsel), .ready_o(seq_ready),
    .eoi_spec_o(eoi_spec), .eoi_ns_o(eoi_ns), .eoi_lvl_o(eoi_lvl)
  );

  irq_edge_det #(.N(N_IN)) u_edge (
    .clk_i, .rst_ni, .lvl_i(irq_req_i), .rise_o(rise)
  );

  assign pend = irr_q & ~mask;

  irq_prio_res #(.N(N_IN), .IW(IDX_W)) u_prio (
    .pend_i(pend), .isv_i(isr_q), .any_o(pend_any), .idx_o(best), .open_o(path_open)
  );

  assign ack_oh = (ack_i && pend_any) ? (N_IN'(1) << best) : '0;

  always_comb begin
    eoi_clr = '0;
    if (eoi_spec)    eoi_clr = N_IN'(1) << eoi_lvl;
    else if (eoi_ns) eoi_clr = isr_q & (~isr_q + N_IN'(1)); // lowest set bit
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irr_q <= (irr_q & ~ack_oh) | rise;
      isr_q <= (isr_q & ~eoi_clr) | ack_oh;
    end
  end

  assign int_o    = pend_any && path_open;
  assign vector_o = base + DW'(best);

  always_comb begin
    if (addr_i)                rdata_o = DW'(mask);
    else if (rsel == RSEL_REQ) rdata_o = DW'(irr_q);
    else if (rsel == RSEL_ISV) rdata_o = DW'(isr_q);
    else                       rdata_o = '0;
  end
endmodule

// File: rtl/irq_ctrl8_chk.sv
module irq_ctrl8_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       addr_i,
  input logic [7:0] wdata_i,
  input logic       ack_i,
  input logic       int_o,
  input logic       ready_i,
  input logic [7:0] irr_i,
  input logic [7:0] isr_i,
  input logic [7:0] mask_i
);
  p_int_needs_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> |(irr_i & ~mask_i));

  p_mask_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i) |=> $stable(mask_i));

  p_req_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> ((irr_i & $past(irr_i)) == $past(irr_i)));

  p_ack_moves_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !wr_i && |(irr_i & ~mask_i) && ((isr_i & irr_i & ~mask_i) == 8'h00)
    |=> $countones(isr_i) == $past($countones(isr_i)) + 1);

  p_spec_eoi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && wr_i && !addr_i && wdata_i[7:3] == 5'b01100 && !ack_i
    |=> !isr_i[$past(wdata_i[2:0])]);

  p_ns_eoi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && wr_i && !addr_i && wdata_i[7:3] == 5'b00100 && !ack_i && |isr_i
    |=> $countones(isr_i) == $past($countones(isr_i)) - 1);
endmodule

bind irq_ctrl8 irq_ctrl8_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .ack_i(ack_i), .int_o(int_o), .ready_i(seq_ready),
  .irr_i(irr_q), .isr_i(isr_q), .mask_i(mask)
);

// File: tb/irq_ctrl8_tb.sv
module irq_ctrl8_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] irq_req_i = '0;
  logic       ack_i = 1'b0;
  logic       int_o;
  logic [7:0] vector_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_irr = '0, m_isr = '0, m_mask = '0, m_base = '0, m_prev = '0;

  always #10 clk_i = ~clk_i;

  irq_ctrl8 u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic int low_idx(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) low_idx = i;
    if (v == 0) low_idx = 0;
  endfunction

  function automatic logic exp_int();
    logic [7:0] p = m_irr & ~m_mask;
    int b = low_idx(p);
    return (p != 0) && ((m_isr & ((8'h2 << b) - 8'h1)) == 0);
  endfunction

  function automatic logic [7:0] exp_vec();
    return m_base + 8'(low_idx(m_irr & ~m_mask));
  endfunction

  task automatic step(input logic [7:0] req, input logic ack);
    logic [7:0] p;
    irq_req_i = req;
    ack_i = ack;
    p = m_irr & ~m_mask;
    if (ack && p != 0) begin
      m_isr = m_isr | (8'h1 << low_idx(p));
      m_irr = m_irr & ~(8'h1 << low_idx(p));
    end
    m_irr = m_irr | (req & ~m_prev);
    m_prev = req;
    @(posedge clk_i);
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic chk_out(input string req);
    chk({req, " int"}, {7'b0, int_o}, {7'b0, exp_int()});
    if (exp_int()) chk({req, " vec"}, vector_o, exp_vec());
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'h5eed_0101));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 int", {7'b0, int_o}, 8'h00);
    rd(0, v); chk("R1 cmd read", v, 8'h00);
    rd(1, v); chk("R1 mask", v, 8'h00);
    wr(1, 8'hFF);
    rd(1, v); chk("R1 data write ignored", v, 8'h00);

    // R3 single mode with option word
    wr(0, 8'h13); wr(1, 8'h20); m_base = 8'h20;
    wr(1, 8'hF0);                               // option word, not mask
    rd(1, v); chk("R3 option not mask", v, 8'h00);
    wr(1, 8'hF0); m_mask = 8'hF0;
    rd(1, v); chk("R5 mask readback", v, 8'hF0);
    wr(1, 8'h00); m_mask = 8'h00;

    // R4 R7 priority and vector
    step(8'h24, 0);
    chk_out("R7");
    chk("R4 vector", vector_o, 8'h22);
    rd(0, v); chk("R12 default request read", v, 8'h24);
    step(8'h24, 1);
    chk("R7 blocked by in-service", {7'b0, int_o}, 8'h00);
    rd(0, v); chk("R8 request cleared", v, 8'h20);
    wr(0, 8'h0B);
    rd(0, v); chk("R12 in-service read", v, 8'h04);
    step(8'h24, 0); step(8'h24, 0);
    wr(0, 8'h0A);
    rd(0, v); chk("R6 level held no reset", v, 8'h20);

    // nesting
    step(8'h26, 0);
    chk_out("R7 nest");
    chk("R4 nest vector", vector_o, 8'h21);
    step(8'h26, 1);
    wr(0, 8'h20); m_isr = m_isr & (m_isr - 8'h1);
    wr(0, 8'h0B);
    rd(0, v); chk("R10 lowest cleared", v, 8'h04);
    wr(0, 8'h62); m_isr = m_isr & ~8'h04;
    rd(0, v); chk("R9 specific cleared", v, 8'h00);
    chk_out("R7 after eoi");
    chk("R4 vector base+5", vector_o, 8'h25);

    // R11 ignored commands
    step(8'h26, 1);
    wr(0, 8'hA0); wr(0, 8'h00); wr(0, 8'h40);
    rd(0, v); chk("R11 ignored commands", v, 8'h20);
    wr(0, 8'h20); m_isr = 8'h00;
    rd(0, v); chk("R10 single bit", v, 8'h00);
    wr(0, 8'h08);
    rd(0, v); chk("R12 select 00 zero", v, 8'h00);
    wr(0, 8'h09);
    rd(0, v); chk("R12 select 01 zero", v, 8'h00);

    // R8 ack with nothing pending
    step(8'h26, 1);
    wr(0, 8'h0B);
    rd(0, v); chk("R8 empty ack no effect", v, 8'h00);

    // R5 masked request
    wr(1, 8'h01); m_mask = 8'h01;
    step(8'h27, 0);
    chk("R5 masked no int", {7'b0, int_o}, 8'h00);
    step(8'h27, 1);
    rd(0, v); chk("R8 masked ack no effect", v, 8'h00);
    wr(0, 8'h0A);
    rd(0, v); chk("R5 masked still latched", v, 8'h01);
    wr(1, 8'h00); m_mask = 8'h00;
    chk_out("R5 unmasked");

    // R2 R3 restart in cascade mode with option word
    wr(0, 8'h11);
    wr(1, 8'h40); m_base = 8'h40;
    rd(1, v); chk("R2 base not mask", v, 8'h00);
    wr(1, 8'h55);
    wr(1, 8'h66);
    rd(1, v); chk("R3 chain+option consumed", v, 8'h00);
    wr(1, 8'h0F); m_mask = 8'h0F;
    rd(1, v); chk("R3 ready after last word", v, 8'h0F);
    wr(1, 8'h00); m_mask = 8'h00;
    chk("R2 new base vector", vector_o, 8'h40);

    // random phase
    wr(0, 8'h0A);
    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 16;
      if (r == 0) begin
        logic [7:0] mk = 8'($urandom);
        wr(1, mk); m_mask = mk;
      end else if (r == 1) begin
        wr(0, 8'h20); m_isr = m_isr & (m_isr - 8'h1);
      end else begin
        step(8'($urandom), ($urandom % 3) == 0);
      end
      chk_out("R7 random");
      rd(0, v); chk("R6 random request reg", v, m_irr);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule